// File: doc/BRIEF.md
# Programmable Trigger Pulse Generator

This block drives one trigger line whose timing is set in whole ticks of a 10 MHz timebase. The timebase is a one-cycle strobe derived inside the block by dividing the 100 MHz system clock. Two generators run side by side. The free-running generator alternates a programmed number of high ticks with a programmed number of low ticks for as long as its enable is held. The one-shot generator emits a single high pulse of programmed length on each rising edge of its start input.

A select bit chooses which of the two generators drives the trigger line. Both generators keep running whichever one is selected. Configuration values are read live, so a new value is used at the next tick where it is compared. With both counts at one tick the fastest trigger is 5 MHz. With both counts at full scale the slowest is roughly 75 Hz.

Top module: `trig_pulse_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, trig_out is 0. The tick divider restarts at zero, so the first tick strobe falls on the tenth clock edge after release.
- R2: The internal tick is a one-cycle strobe that fires once every TICK_DIV (10) system clocks. No phase or count changes between strobes.
- R3: With run_en high and sel_shot 0, trig_out is high for run_hi ticks and then low for run_lo ticks, repeating. In steady state the period is 10*(run_hi+run_lo) clocks.
- R4: A count value of 0 in run_hi, run_lo or shot_hi is treated as 1 tick, so no phase is ever zero length.
- R5: When run_en is low, the free-running output is 0 from the next clock and its state returns to the start of the high phase. After run_en rises, the output is high from the next clock.
- R6: A 0-to-1 transition of shot_go while the one-shot is idle starts a pulse on the next clock. The pulse ends at the tick on which shot_hi ticks have elapsed, so it is 10*(shot_hi-1)+1 to 10*shot_hi clocks wide.
- R7: Holding shot_go high yields exactly one pulse, and the one-shot stays low afterwards until shot_go falls and rises again.
- R8: A rising edge of shot_go while a pulse is in progress is ignored and does not lengthen or restart the pulse.
- R9: sel_shot = 1 routes the one-shot output to trig_out and sel_shot = 0 routes the free-running output. The choice takes effect in the same cycle.
- R10: run_hi = run_lo = 1 gives a 20-clock (5 MHz) trigger period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_hi | input | 16 | Free-running high time in ticks |
| run_lo | input | 16 | Free-running low time in ticks |
| shot_hi | input | 16 | One-shot high time in ticks |
| run_en | input | 1 | Free-running generator enable |
| shot_go | input | 1 | One-shot start (rising edge) |
| sel_shot | input | 1 | Output select: 1 one-shot, 0 free-running |
| trig_out | output | 1 | Trigger output |

## Verification
A corrupted phase or count register shows up at trig_out at the next tick strobe, no more than ten clocks later. It appears as an edge that is early or late against a tick-accurate model. A wrong divider value moves every later edge, so the error is seen within one trigger period. A one-shot busy flag that sets or clears wrongly shows up as an extra, missing or stretched pulse while sel_shot is 1. The bench compares trig_out with its model on every clock, so the first cycle of any such error is reported.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/trig_tick_div.sv
module trig_tick_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = (div_q == LAST);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/trig_run_gen.sv
module trig_run_gen
  import trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             out_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic [CNT_W:0]   len, nxt;

  always_comb begin
    len = (ph_q == PH_HIGH) ? {1'b0, hi_i} : {1'b0, lo_i};
    if (len == '0) len = 1;
    nxt = {1'b0, cnt_q} + 1'b1;
  end

  always_comb begin
    run_d = en_i;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      ph_d  = PH_HIGH;
      cnt_d = '0;
    end else if (run_q && tick_i) begin
      if (nxt >= len) begin
        ph_d  = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        cnt_d = '0;
      end else begin
        cnt_d = nxt[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_o = run_q && (ph_q == PH_HIGH);

  // R5
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !out_o);
  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(ph_q));
endmodule

// File: rtl/trig_shot_gen.sv
module trig_shot_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             out_o
);
  logic             busy_q, busy_d;
  logic             go_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   len, nxt;
  logic             start;

  always_comb begin
    len = (hi_i == '0) ? 1 : {1'b0, hi_i};
    nxt = {1'b0, cnt_q} + 1'b1;
    start = go_i && !go_q && !busy_q;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && tick_i) begin
      if (nxt >= len) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = nxt[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      go_q   <= go_i;
      cnt_q  <= cnt_d;
    end
  end

  assign out_o = busy_q;

  // R6
  shot_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> busy_q);
  // R8
  shot_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] run_hi,
  input  logic [CNT_W-1:0] run_lo,
  input  logic [CNT_W-1:0] shot_hi,
  input  logic             run_en,
  input  logic             shot_go,
  input  logic             sel_shot,
  output logic             trig_out
);
  logic tick, run_out, shot_out;

  trig_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  trig_run_gen #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(run_en),
    .hi_i(run_hi), .lo_i(run_lo), .out_o(run_out));

  trig_shot_gen #(.CNT_W(CNT_W)) u_shot (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(shot_go),
    .hi_i(shot_hi), .out_o(shot_out));

  assign trig_out = sel_shot ? shot_out : run_out;

  // R9
  sel_run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_shot && !run_en) |=> (sel_shot || !trig_out));
  // R1
  rst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !trig_out);
endmodule

// File: tb/trig_pulse_gen_tb.sv
module trig_pulse_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] run_hi = 16'd1, run_lo = 16'd1, shot_hi = 16'd1;
  logic        run_en = 1'b0, shot_go = 1'b0, sel_shot = 1'b0;
  logic        trig_out;

  int n_cmp = 0, n_bad = 0;
  string cur = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  trig_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run_hi(run_hi), .run_lo(run_lo),
    .shot_hi(shot_hi), .run_en(run_en), .shot_go(shot_go),
    .sel_shot(sel_shot), .trig_out(trig_out));

  // behavioural reference: integers for time in ticks
  int m_div, m_left, m_busy, m_sleft;
  bit m_run, m_high, m_goprev;

  function automatic int eff(input logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_run = 0; m_high = 1; m_left = -1;
      m_busy = 0; m_sleft = 0; m_goprev = 0;
    end else begin
      bit tk;
      tk = (m_div == 9);
      m_div = tk ? 0 : m_div + 1;
      if (!run_en) begin
        m_run = 0; m_high = 1; m_left = -1;
      end else begin
        if (m_run && tk) begin
          if (m_left < 0) m_left = 1;
          else m_left = m_left + 1;
          if (m_left >= eff(m_high ? run_hi : run_lo)) begin
            m_high = !m_high; m_left = -1;
          end
        end
        m_run = 1;
      end
      if (shot_go && !m_goprev && !m_busy) begin
        m_busy = 1; m_sleft = 0;
      end else if (m_busy && tk) begin
        m_sleft = m_sleft + 1;
        if (m_sleft >= eff(shot_hi)) m_busy = 0;
      end
      m_goprev = shot_go;
    end
  end

  function automatic bit model_out();
    return sel_shot ? (m_busy != 0) : (m_run && m_high);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check(cur, trig_out, model_out());

  task automatic measure(input int n, output int hi_cyc, output int rises, output int period);
    int last_rise = -1; bit prev = trig_out;
    hi_cyc = 0; rises = 0; period = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig_out) hi_cyc++;
      if (trig_out && !prev) begin
        if (last_rise >= 0) period = i - last_rise;
        last_rise = i; rises++;
      end
      prev = trig_out;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int h, r, p;
    idle(3);
    check("R1", trig_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", trig_out, 0);
    // R10 fastest rate
    cur = "R10"; run_hi = 1; run_lo = 1; run_en = 1;
    idle(40);
    measure(100, h, r, p);
    check("R10", p, 20);
    check("R10", h, 50);
    // R3 asymmetric
    cur = "R3"; run_hi = 3; run_lo = 5;
    idle(200);
    measure(240, h, r, p);
    check("R3", p, 80);
    check("R3", h, 90);
    // R4 zero counts
    cur = "R4"; run_hi = 0; run_lo = 0;
    idle(100);
    measure(100, h, r, p);
    check("R4", p, 20);
    // R5 disable/enable
    cur = "R5"; run_hi = 7; run_lo = 2;
    idle(35);
    run_en = 0;
    @(negedge clk);
    check("R5", trig_out, 0);
    idle(23);
    run_en = 1;
    @(negedge clk);
    check("R5", trig_out, 1);
    idle(150);
    // R9 mux
    cur = "R9"; sel_shot = 1;
    @(negedge clk);
    check("R9", trig_out, 0);
    sel_shot = 0; idle(57);
    // R6 one-shot width
    cur = "R6"; run_en = 0; sel_shot = 1; shot_hi = 4;
    idle(5);
    shot_go = 1; @(negedge clk); shot_go = 0;
    check("R6", trig_out, 1);
    measure(80, h, r, p);
    check("R6", (h >= 30 && h <= 39) ? 1 : 0, 1);
    // R7 held enable
    cur = "R7"; shot_hi = 2;
    shot_go = 1;
    measure(300, h, r, p);
    check("R7", r, 1);
    shot_go = 0;
    idle(3);
    // R8 retrigger ignored
    cur = "R8"; shot_hi = 3;
    shot_go = 1; @(negedge clk); shot_go = 0;
    idle(12);
    shot_go = 1; @(negedge clk); shot_go = 0;
    measure(80, h, r, p);
    check("R8", r, 0);
    check("R8", (h + 14 >= 21 && h + 14 <= 30) ? 1 : 0, 1);
    // R4 zero one-shot
    cur = "R4"; shot_hi = 0; idle(5);
    shot_go = 1; @(negedge clk); shot_go = 0;
    measure(30, h, r, p);
    check("R4", (h + 1 >= 1 && h + 1 <= 10) ? 1 : 0, 1);
    // R9 live switching with both running
    cur = "R9"; run_en = 1; run_hi = 2; run_lo = 3; shot_hi = 6;
    for (int k = 0; k < 8; k++) begin
      shot_go = (k % 3 == 0); sel_shot = k[0];
      idle(23 + k);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule